// File: doc/BRIEF.md
# Motion Sensor SPI Register Port

This block is the serial front end of a motion sensor. A host drives a clock, a data line and an active-low select. The block turns that traffic into register accesses toward the sensor core and returns read data on a serial output that it can switch off. The bus clock idles high. The host changes its data on falling clock edges, and the block samples on rising edges. All bus inputs are synchronised into the faster system clock, and every edge is detected in that domain, so the system clock must be well above the bus clock.

A normal transaction is two bytes. The first byte holds a direction flag in bit 7 and a 7-bit address. The second byte is either write data from the host or read data from the block. Identity registers are answered locally. Every other readable or writable register is reached through a combinational read port and a one-cycle write strobe toward the core. Reading the burst address makes the block read seven motion registers at once, on consecutive system cycles, into a snapshot. It then streams the snapshot out as a single uninterrupted run. A special write pulses a soft-reset strobe toward the core.

The core uses each read strobe as a read-clear event. In a burst, the host must leave at least a half clock period between the last address edge and the first data falling edge. During that time the snapshot is gathered.

Top module: `msns_spi_regport`

## Requirements
- R1: A transaction is an address byte followed by a data byte, both MSB first. Bit 7 of the address byte is 1 for a write and 0 for a read, and bits 6..0 hold the address. Several transactions may follow each other inside one select-low frame.
- R2: Input data is taken on rising bus clock edges. The serial output changes only after a falling bus clock edge and holds its value until the next one.
- R3: While the select is high, the output enable is low, and clock or data activity causes no register access.
- R4: Raising the select partway through a byte aborts the transaction with no access. The next frame starts cleanly with an address byte.
- R5: A write to one of the writable core addresses 0x02, 0x0B, 0x10, 0x11 or 0x2E gives exactly one write strobe, carrying that address and the data byte.
- R6: A write to any other address, whether read-only or reserved, gives no write strobe. The one exception is the reset address 0x3A.
- R7: A read of a readable core address (0x02 to 0x0F, 0x11, 0x2E) gives one read strobe, sent when the address byte completes. The core's data returns as the data byte.
- R8: Identity reads are answered locally without a read strobe: 0x00 gives 0x0D, 0x01 gives 0x02, 0x3F gives 0xF2 and 0x3E gives 0xFD. Any other address that has no readable register returns 0x00.
- R9: A read of address 0x42 gives seven read strobes, to addresses 0x02 through 0x08, right after the address byte. The host then receives those seven values in ascending address order, with no further address byte.
- R10: The host may end a burst after any number of bytes by raising the select, for example after three. The next frame is handled normally.
- R11: Once all seven burst bytes are sent, the port ignores further bytes. It gives no strobes, and the output stays 0 until the select has been raised.
- R12: Writing 0x5A to address 0x3A pulses the soft-reset output once and gives no write strobe. Any other value written there does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Bus clock from the host, idle high |
| sdi_i | input | 1 | Serial data from the host |
| cs_n_i | input | 1 | Active-low select |
| sdo_o | output | 1 | Serial data to the host |
| sdo_oe_o | output | 1 | Output enable for the serial data driver |
| reg_rd_o | output | 1 | Read strobe toward the core (read-clear event) |
| reg_wr_o | output | 1 | Write strobe toward the core |
| reg_addr_o | output | 7 | Register address toward the core |
| reg_wdata_o | output | 8 | Write data toward the core |
| reg_rdata_i | input | 8 | Read data from the core, valid in the same cycle as the address |
| soft_rst_o | output | 1 | One-cycle soft-reset request |

## Verification
Single two-byte frames are checked against a core model that returns 0x40 plus the address. That shows whether data came from the core, from the local identity table, or was forced to zero. Back-to-back transactions inside one frame test whether byte framing carries over correctly between transactions. The bench also uses aborted frames, full bursts, shortened bursts, and bytes clocked after a finished burst. Comparing strobe counts across these cases separates a proper abort or lock from a port that still acts on the stray bits. Writes to the reset address with the key value and with a near-miss value check that only the exact key triggers the reset.

// File: rtl/msns_spi_pkg.sv
package msns_spi_pkg;
   typedef enum logic [2:0] {
      ST_ADDR,
      ST_WDATA,
      ST_RDATA,
      ST_GATHER,
      ST_BURST,
      ST_LOCK
   } port_st_t;

   localparam logic [6:0] BURST_ADDR = 7'h42;
   localparam logic [6:0] BURST_BASE = 7'h02;
   localparam logic [6:0] RESET_ADDR = 7'h3A;
   localparam logic [7:0] RESET_KEY  = 8'h5A;
endpackage

// File: rtl/msns_sync.sv
module msns_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("msns_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
      end else begin
         chain_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/msns_frame.sv
module msns_frame #(
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          act_i,
   input  logic          rise_i,
   input  logic          sdi_i,
   output logic          byte_done_o,
   output logic [BW-1:0] byte_o
);
   localparam int CW = $clog2(BW);

   generate
      if (BW < 2) begin : g_bad_bw
         $error("msns_frame: BW must be at least 2");
      end
   endgenerate

   logic [CW-1:0] bit_q;
   logic [BW-1:0] sh_q;
   logic [BW-1:0] sh_nx;

   assign sh_nx = {sh_q[BW-2:0], sdi_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_q       <= '0;
         sh_q        <= '0;
         byte_o      <= '0;
         byte_done_o <= 1'b0;
      end else begin
         byte_done_o <= 1'b0;
         if (!act_i) begin
            bit_q <= '0;
         end else if (rise_i) begin
            sh_q <= sh_nx;
            if (bit_q == CW'(BW-1)) begin
               bit_q       <= '0;
               byte_o      <= sh_nx;
               byte_done_o <= 1'b1;
            end else begin
               bit_q <= bit_q + CW'(1);
            end
         end
      end
   end

   // R1
   byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_done_o |=> !byte_done_o);
endmodule

// File: rtl/msns_regmap.sv
module msns_regmap #(
   parameter logic [7:0] PROD_ID = 8'h0D,
   parameter logic [7:0] REV_ID  = 8'h02
) (
   input  logic [6:0] addr_i,
   output logic       core_rd_o,
   output logic       core_wr_o,
   output logic [7:0] local_o
);
   always_comb begin
      core_rd_o = ((addr_i >= 7'h02) && (addr_i <= 7'h0F)) ||
                  (addr_i == 7'h11) || (addr_i == 7'h2E);
      core_wr_o = (addr_i == 7'h02) || (addr_i == 7'h0B) || (addr_i == 7'h10) ||
                  (addr_i == 7'h11) || (addr_i == 7'h2E);
      case (addr_i)
         7'h00:   local_o = PROD_ID;
         7'h01:   local_o = REV_ID;
         7'h3E:   local_o = ~REV_ID;
         7'h3F:   local_o = ~PROD_ID;
         default: local_o = 8'h00;
      endcase
   end

   // R8
   always_comb begin
      local_core_excl_chk: assert (!(core_rd_o && (local_o != 8'h00)));
   end
endmodule

// File: rtl/msns_spi_regport.sv
module msns_spi_regport
   import msns_spi_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter int         BURST_LEN   = 7,
   parameter logic [7:0] PROD_ID     = 8'h0D,
   parameter logic [7:0] REV_ID      = 8'h02
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sck_i,
   input  logic       sdi_i,
   input  logic       cs_n_i,
   output logic       sdo_o,
   output logic       sdo_oe_o,
   output logic       reg_rd_o,
   output logic       reg_wr_o,
   output logic [6:0] reg_addr_o,
   output logic [7:0] reg_wdata_o,
   input  logic [7:0] reg_rdata_i,
   output logic       soft_rst_o
);
   localparam int SNAP_W = BURST_LEN * 8;
   localparam int GC_W   = $clog2(BURST_LEN + 1);

   generate
      if (BURST_LEN < 1 || BURST_LEN > 7) begin : g_bad_burst
         $error("msns_spi_regport: BURST_LEN must be 1..7");
      end
   endgenerate

   // bus input synchronisation and edge detection
   logic sck_s, sdi_s, cs_n_s, sck_d;
   logic act, rise, fall;

   msns_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b101)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({sck_i, sdi_i, cs_n_i}),
      .q_o   ({sck_s, sdi_s, cs_n_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_d <= 1'b1;
      else        sck_d <= sck_s;
   end

   assign act  = !cs_n_s;
   assign rise = act && sck_s && !sck_d;
   assign fall = act && !sck_s && sck_d;

   // byte framing
   logic       byte_done, bd;
   logic [7:0] byte_v;

   msns_frame #(.BW(8)) frame_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .act_i       (act),
      .rise_i      (rise),
      .sdi_i       (sdi_s),
      .byte_done_o (byte_done),
      .byte_o      (byte_v)
   );

   assign bd = byte_done && act;

   // state
   port_st_t          st_q;
   logic [6:0]        addr_q;
   logic [SNAP_W-1:0] tx_q;
   logic [GC_W-1:0]   gcnt_q, bcnt_q;
   logic              sdo_q;

   // address decode
   logic [6:0] map_addr;
   logic       map_rd, map_wr;
   logic [7:0] map_local;

   assign map_addr = (st_q == ST_ADDR) ? byte_v[6:0] : addr_q;

   msns_regmap #(.PROD_ID(PROD_ID), .REV_ID(REV_ID)) map_i (
      .addr_i    (map_addr),
      .core_rd_o (map_rd),
      .core_wr_o (map_wr),
      .local_o   (map_local)
   );

   // core-side strobes
   always_comb begin
      reg_rd_o    = 1'b0;
      reg_wr_o    = 1'b0;
      soft_rst_o  = 1'b0;
      reg_addr_o  = map_addr;
      reg_wdata_o = byte_v;
      if (st_q == ST_GATHER) begin
         reg_rd_o   = 1'b1;
         reg_addr_o = BURST_BASE + 7'(gcnt_q);
      end else if (bd) begin
         if (st_q == ST_ADDR && !byte_v[7] && byte_v[6:0] != BURST_ADDR && map_rd)
            reg_rd_o = 1'b1;
         if (st_q == ST_WDATA) begin
            if (addr_q == RESET_ADDR) soft_rst_o = (byte_v == RESET_KEY);
            else                      reg_wr_o   = map_wr;
         end
      end
   end

   // transaction sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_ADDR;
         addr_q <= '0;
         tx_q   <= '0;
         gcnt_q <= '0;
         bcnt_q <= '0;
         sdo_q  <= 1'b0;
      end else if (!act) begin
         st_q   <= ST_ADDR;
         gcnt_q <= '0;
         bcnt_q <= '0;
         sdo_q  <= 1'b0;
      end else begin
         case (st_q)
            ST_ADDR: if (bd) begin
               addr_q <= byte_v[6:0];
               if (byte_v[7]) begin
                  st_q <= ST_WDATA;
               end else if (byte_v[6:0] == BURST_ADDR) begin
                  st_q   <= ST_GATHER;
                  gcnt_q <= '0;
               end else begin
                  st_q <= ST_RDATA;
                  tx_q <= SNAP_W'(map_rd ? reg_rdata_i : map_local) << (SNAP_W - 8);
               end
            end
            ST_WDATA, ST_RDATA: if (bd) st_q <= ST_ADDR;
            ST_GATHER: begin
               tx_q   <= (tx_q << 8) | SNAP_W'(reg_rdata_i);
               gcnt_q <= gcnt_q + GC_W'(1);
               if (gcnt_q == GC_W'(BURST_LEN - 1)) begin
                  st_q   <= ST_BURST;
                  bcnt_q <= '0;
               end
            end
            ST_BURST: if (bd) begin
               if (bcnt_q == GC_W'(BURST_LEN - 1)) st_q <= ST_LOCK;
               else                                bcnt_q <= bcnt_q + GC_W'(1);
            end
            default: ;
         endcase
         if (fall) begin
            if (st_q == ST_RDATA || st_q == ST_BURST) begin
               sdo_q <= tx_q[SNAP_W-1];
               tx_q  <= tx_q << 1;
            end else begin
               sdo_q <= 1'b0;
            end
         end
      end
   end

   assign sdo_o    = sdo_q;
   assign sdo_oe_o = act;

   // R11
   lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_LOCK) |-> !(reg_rd_o || reg_wr_o || soft_rst_o));

   // R4
   abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !act |=> (st_q == ST_ADDR));

   // R9
   gather_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_GATHER && $past(st_q) == ST_GATHER) |->
         (reg_addr_o == $past(reg_addr_o) + 7'd1));

   // R2
   sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act && $past(act) && !$past(fall)) |-> $stable(sdo_q));

   // R5
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rd_o && reg_wr_o));
endmodule

// File: tb/msns_spi_regport_tb_top.sv
`timescale 1ns/1ps
module msns_spi_regport_tb_top;
   localparam int HALF = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sck = 1'b1, sdi = 1'b0, cs_n = 1'b1;
   logic       sdo, sdo_oe, reg_rd, reg_wr, soft_rst;
   logic [6:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;

   int total = 0, bad = 0, done = 0;
   int rd_cnt = 0, wr_cnt = 0, rst_cnt = 0;
   logic [6:0] last_ra = '0, last_wa = '0;
   logic [7:0] last_wd = '0;

   always #2.5 clk = ~clk;

   msns_spi_regport dut_i (
      .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdi_i(sdi), .cs_n_i(cs_n),
      .sdo_o(sdo), .sdo_oe_o(sdo_oe), .reg_rd_o(reg_rd), .reg_wr_o(reg_wr),
      .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata),
      .soft_rst_o(soft_rst)
   );

   // core model: value is 0x40 plus the address
   assign reg_rdata = 8'h40 + {1'b0, reg_addr};

   always @(posedge clk) begin
      if (rst_n) begin
         if (reg_rd) begin rd_cnt++; last_ra = reg_addr; end
         if (reg_wr) begin wr_cnt++; last_wa = reg_addr; last_wd = reg_wdata; end
         if (soft_rst) rst_cnt++;
      end
   end

   task automatic waitc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [63:0] actv, input logic [63:0] expv);
      total++;
      if (actv !== expv) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, actv, expv);
      end
   endtask

   task automatic spi_byte(input logic [7:0] b, output logic [7:0] rx);
      for (int i = 7; i >= 0; i--) begin
         sck = 1'b0; sdi = b[i];
         waitc(HALF);
         rx[i] = sdo;
         sck = 1'b1;
         waitc(HALF);
      end
   endtask

   task automatic xfer(input logic [7:0] b0, input logic [7:0] b1, output logic [7:0] rx);
      logic [7:0] d;
      cs_n = 1'b0; waitc(HALF);
      spi_byte(b0, d);
      spi_byte(b1, rx);
      waitc(HALF); cs_n = 1'b1; waitc(4*HALF);
   endtask

   task automatic t_reset();
      chk("R3 oe after reset", sdo_oe, 1'b0);
      chk("R3 strobes after reset", {reg_rd, reg_wr, soft_rst}, 3'b000);
   endtask

   task automatic t_identity();
      logic [7:0] rx; int r0;
      r0 = rd_cnt;
      xfer(8'h00, 8'h00, rx); chk("R8 id 0x00", rx, 8'h0D);
      xfer(8'h01, 8'h00, rx); chk("R8 id 0x01", rx, 8'h02);
      xfer(8'h3E, 8'h00, rx); chk("R8 id 0x3E", rx, 8'hFD);
      xfer(8'h3F, 8'h00, rx); chk("R8 id 0x3F", rx, 8'hF2);
      xfer(8'h20, 8'h00, rx); chk("R8 reserved read", rx, 8'h00);
      chk("R8 no core strobe", rd_cnt - r0, 0);
   endtask

   task automatic t_core_read();
      logic [7:0] rx; int r0;
      r0 = rd_cnt;
      xfer(8'h05, 8'h00, rx);
      chk("R7 core read data", rx, 8'h45);
      chk("R7 one strobe", rd_cnt - r0, 1);
      chk("R7 strobe addr", last_ra, 7'h05);
      xfer(8'h2E, 8'h00, rx);
      chk("R7 core read 0x2E", rx, 8'h6E);
   endtask

   task automatic t_write();
      logic [7:0] rx; int w0;
      w0 = wr_cnt;
      xfer(8'h91, 8'hA7, rx);
      chk("R5 one write strobe", wr_cnt - w0, 1);
      chk("R5 write addr", last_wa, 7'h11);
      chk("R5 write data", last_wd, 8'hA7);
      xfer(8'h82, 8'h00, rx);
      chk("R5 motion write addr", last_wa, 7'h02);
   endtask

   task automatic t_write_ro();
      logic [7:0] rx; int w0, s0;
      w0 = wr_cnt; s0 = rst_cnt;
      xfer(8'h83, 8'h55, rx);
      xfer(8'h80, 8'h00, rx);
      xfer(8'hB0, 8'h12, rx);
      chk("R6 no write strobes", wr_cnt - w0, 0);
      chk("R6 no reset", rst_cnt - s0, 0);
      xfer(8'h00, 8'h00, rx);
      chk("R6 id unchanged", rx, 8'h0D);
   endtask

   task automatic t_soft();
      logic [7:0] rx; int w0, s0;
      w0 = wr_cnt; s0 = rst_cnt;
      xfer(8'hBA, 8'h5A, rx);
      chk("R12 reset pulse", rst_cnt - s0, 1);
      xfer(8'hBA, 8'h5B, rx);
      chk("R12 wrong key", rst_cnt - s0, 1);
      chk("R12 no write strobe", wr_cnt - w0, 0);
   endtask

   task automatic t_hiz();
      logic [7:0] rx; int w0, r0;
      w0 = wr_cnt; r0 = rd_cnt;
      spi_byte(8'h91, rx);
      spi_byte(8'h22, rx);
      waitc(HALF);
      chk("R3 oe off when deselected", sdo_oe, 1'b0);
      chk("R3 no strobes when deselected", (wr_cnt - w0) + (rd_cnt - r0), 0);
      cs_n = 1'b0; waitc(HALF);
      chk("R3 oe on when selected", sdo_oe, 1'b1);
      cs_n = 1'b1; waitc(4*HALF);
   endtask

   task automatic t_abort();
      logic [7:0] rx; int w0;
      w0 = wr_cnt;
      cs_n = 1'b0; waitc(HALF);
      for (int i = 7; i >= 3; i--) begin
         sck = 1'b0; sdi = 1'b1; waitc(HALF);
         sck = 1'b1; waitc(HALF);
      end
      cs_n = 1'b1; waitc(4*HALF);
      xfer(8'h01, 8'h00, rx);
      chk("R4 clean read after abort", rx, 8'h02);
      chk("R4 no write from aborted bits", wr_cnt - w0, 0);
   endtask

   task automatic t_multi();
      logic [7:0] rx, d;
      cs_n = 1'b0; waitc(HALF);
      spi_byte(8'h00, d); spi_byte(8'h00, rx);
      chk("R1 first of two in frame", rx, 8'h0D);
      spi_byte(8'h8B, d); spi_byte(8'h3C, d);
      waitc(HALF); cs_n = 1'b1; waitc(4*HALF);
      chk("R1 second in frame addr", last_wa, 7'h0B);
      chk("R2 second in frame data", last_wd, 8'h3C);
   endtask

   task automatic t_burst();
      logic [7:0] rx; int r0, w0;
      r0 = rd_cnt;
      cs_n = 1'b0; waitc(HALF);
      spi_byte(8'h42, rx);
      for (int k = 0; k < 7; k++) begin
         spi_byte(8'h00, rx);
         chk("R9 burst byte", rx, 8'h42 + 8'(k));
      end
      chk("R9 seven read strobes", rd_cnt - r0, 7);
      w0 = wr_cnt; r0 = rd_cnt;
      spi_byte(8'h91, rx);
      chk("R11 locked output zero", rx, 8'h00);
      spi_byte(8'h33, rx);
      chk("R11 locked no strobes", (wr_cnt - w0) + (rd_cnt - r0), 0);
      waitc(HALF); cs_n = 1'b1; waitc(4*HALF);
      xfer(8'h05, 8'h00, rx);
      chk("R11 port usable after deselect", rx, 8'h45);
   endtask

   task automatic t_burst_short();
      logic [7:0] rx;
      cs_n = 1'b0; waitc(HALF);
      spi_byte(8'h42, rx);
      for (int k = 0; k < 3; k++) begin
         spi_byte(8'h00, rx);
         chk("R10 short burst byte", rx, 8'h42 + 8'(k));
      end
      waitc(HALF); cs_n = 1'b1; waitc(4*HALF);
      xfer(8'h01, 8'h00, rx);
      chk("R10 normal read after short burst", rx, 8'h02);
   endtask

   initial begin
      waitc(10);
      rst_n = 1'b1;
      waitc(10);
      t_reset();
      t_identity();
      t_core_read();
      t_write();
      t_write_ro();
      t_soft();
      t_hiz();
      t_abort();
      t_multi();
      t_burst();
      t_burst_short();
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (done == 0) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule